// File: doc/BRIEF.md
# Fixed-Window Instruction Pre-Decoder

This block sits between instruction fetch and the instruction queue. Each fetch block is a 16-byte window. It arrives with a per-byte start mask and a per-byte flag for length-changing prefixes. A bit says whether the window's final instruction runs on into the next window. A count gives how many leading bytes of the window finish an instruction left open by the thread's previous window. From these the block produces instruction records, each giving a start offset, a length, a spanning flag and a thread id. It produces up to six records per cycle.

A window is held until every instruction that starts in it has been emitted. No two windows are ever mixed in one cycle. An instruction that crosses the window end is stored per thread. It is emitted first when that thread's next window arrives. Fetch slots alternate between two threads on every cycle. A window is taken only in its own thread's slot. The instruction queue can stall the output, and a flush drops all held work.

Top module: `predecode_window`

## Requirements
- R1: Each emitted record carries the start byte as its offset. Its length is the distance to the next start bit in the same window, or to the window end (byte 16) when no later start exists and `blk_span` is 0.
- R2: Records appear on lanes 0 upward with no gaps and in ascending offset order, with at most 6 per cycle. A window with 7 starts is emitted over two cycles, as 6 records and then 1.
- R3: `blk_ready` is 1 when no window is held, or when the held window emits its last record this cycle. It is 0 otherwise, so no new window is taken while an older one still has instructions left.
- R4: When `blk_span` is 1, the highest start in the window is not emitted with that window. It is emitted on lane 0 in the first output cycle of the same thread's next window, with `out_span` bit 0 set. Its length is 16 minus its offset plus that window's `blk_spill`.
- R5: `fetch_slot` is 0 in the first cycle after reset and toggles every cycle. A window is accepted only when `blk_valid`, `blk_ready` and `blk_tid == fetch_slot` are all true.
- R6: An output group ends with the first record whose start byte has its `blk_lcp` bit set. After that group, no record is emitted for `LCP_STALL` (default 2) cycles.
- R7: While `iq_stall` is 1, `out_valid` is 0, `blk_ready` is 0 for a held window, and no held state advances. The same records appear once the stall drops.
- R8: `flush` forces `out_valid` and `blk_ready` to 0 in its cycle. It discards the held window and every stored spanning instruction.
- R9: During and after reset, `out_valid` is 0, `blk_ready` is 1 and `fetch_slot` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Drop held window and stored spanning instructions |
| blk_valid | input | 1 | Fetch window present |
| blk_tid | input | 1 | Thread of the fetch window |
| blk_start | input | 16 | Bit i set: an instruction starts at byte i |
| blk_lcp | input | 16 | Bit i set: instruction at byte i has a length-changing prefix |
| blk_span | input | 1 | Highest start continues into the next window |
| blk_spill | input | 4 | Leading bytes finishing the thread's open instruction |
| blk_ready | output | 1 | Window can be taken this cycle |
| fetch_slot | output | 1 | Thread owning this cycle's fetch slot |
| iq_stall | input | 1 | Instruction queue backpressure |
| out_valid | output | 6 | Per-lane record valid |
| out_off | output | 24 | Per-lane start offset, 4 bits per lane, lane 0 lowest |
| out_len | output | 24 | Per-lane length, 4 bits per lane |
| out_span | output | 6 | Per-lane spanning flag |
| out_tid | output | 1 | Thread of this cycle's records |

## Verification
The hardest case to reach is a spanning instruction completed across interleaved threads. The window's tail must be parked for one thread while the other thread's slot goes by, and the continuation must then arrive in the correct slot with a spill count. The stimulus presents the continuation window in the wrong slot first, so it waits one cycle. This shows both that slot gating works and that the stored tail survives the wait. A later sequence flushes between a spanning window and its continuation, and confirms that the tail never appears.

// File: rtl/predecode_window.sv
module predecode_window #(
  parameter int WIN       = 16,
  parameter int LANES     = 6,
  parameter int LCP_STALL = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   blk_valid,
  input  logic                   blk_tid,
  input  logic [WIN-1:0]         blk_start,
  input  logic [WIN-1:0]         blk_lcp,
  input  logic                   blk_span,
  input  logic [$clog2(WIN)-1:0] blk_spill,
  output logic                   blk_ready,
  output logic                   fetch_slot,
  input  logic                   iq_stall,
  output logic [LANES-1:0]       out_valid,
  output logic [LANES*$clog2(WIN)-1:0] out_off,
  output logic [LANES*$clog2(WIN)-1:0] out_len,
  output logic [LANES-1:0]       out_span,
  output logic                   out_tid
);
  localparam int OW = $clog2(WIN);
  localparam int SW = $clog2(LCP_STALL + 2);
  localparam int CW = $clog2(LANES + 1);

  logic           held, htid, hspan, hl_lcp, head_v, head_lcp;
  logic [WIN-1:0] smask, rem, lcpm;
  logic [OW-1:0]  hl_off, head_off, head_len;
  logic [1:0]     pend_v, pend_lcp;
  logic [OW-1:0]  pend_off [2];
  logic [SW-1:0]  stall_cnt;

  logic [OW-1:0]    lenv [WIN];
  logic [OW-1:0]    g_off [LANES];
  logic [OW-1:0]    g_len [LANES];
  logic [LANES-1:0] g_vld;
  logic [WIN-1:0]   take;
  logic             g_lcp;
  logic [CW-1:0]    cnt;
  logic [OW-1:0]    lastpos;

  always_comb begin
    for (int i = 0; i < WIN; i++) begin
      lenv[i] = OW'(WIN - i);
      for (int j = WIN - 1; j > i; j--)
        if (smask[j]) lenv[i] = OW'(j - i);
    end
  end

  always_comb begin
    cnt = '0;
    g_lcp = 1'b0;
    g_vld = '0;
    take = '0;
    for (int l = 0; l < LANES; l++) begin
      g_off[l] = '0;
      g_len[l] = '0;
    end
    if (head_v) begin
      g_vld[0] = 1'b1;
      g_off[0] = head_off;
      g_len[0] = head_len;
      g_lcp = head_lcp;
      cnt = CW'(1);
    end
    for (int i = 0; i < WIN; i++) begin
      if (rem[i] && cnt < CW'(LANES) && !g_lcp) begin
        g_vld[cnt] = 1'b1;
        g_off[cnt] = OW'(i);
        g_len[cnt] = lenv[i];
        take[i] = 1'b1;
        g_lcp = lcpm[i];
        cnt = cnt + 1'b1;
      end
    end
  end

  always_comb begin
    lastpos = '0;
    for (int i = 0; i < WIN; i++)
      if (blk_start[i]) lastpos = OW'(i);
  end

  logic emit_en, finish, accept, byp, src_v, src_lcp;
  logic [OW-1:0] src_off;

  assign emit_en    = held && stall_cnt == '0 && !iq_stall && !flush;
  assign finish     = emit_en && (rem & ~take) == '0;
  assign blk_ready  = (!held || finish) && !flush;
  assign accept     = blk_valid && blk_ready && (blk_tid == fetch_slot);
  assign byp        = finish && hspan && (htid == blk_tid);
  assign src_v      = byp || pend_v[blk_tid];
  assign src_off    = byp ? hl_off : pend_off[blk_tid];
  assign src_lcp    = byp ? hl_lcp : pend_lcp[blk_tid];

  assign out_valid = emit_en ? g_vld : '0;
  assign out_span  = LANES'(emit_en && head_v);
  assign out_tid   = htid;
  always_comb
    for (int l = 0; l < LANES; l++) begin
      out_off[l*OW +: OW] = g_off[l];
      out_len[l*OW +: OW] = g_len[l];
    end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_slot <= 1'b0;
      held <= 1'b0; htid <= 1'b0; hspan <= 1'b0; hl_lcp <= 1'b0; hl_off <= '0;
      smask <= '0; rem <= '0; lcpm <= '0;
      head_v <= 1'b0; head_lcp <= 1'b0; head_off <= '0; head_len <= '0;
      pend_v <= '0; pend_lcp <= '0; pend_off[0] <= '0; pend_off[1] <= '0;
      stall_cnt <= '0;
    end else begin
      fetch_slot <= ~fetch_slot;
      if (flush) begin
        held <= 1'b0;
        head_v <= 1'b0;
        pend_v <= '0;
        stall_cnt <= '0;
      end else begin
        if (stall_cnt != '0) stall_cnt <= stall_cnt - 1'b1;
        else if (emit_en && g_lcp) stall_cnt <= SW'(LCP_STALL);
        if (emit_en) begin
          rem <= rem & ~take;
          head_v <= 1'b0;
        end
        if (finish) begin
          held <= 1'b0;
          if (hspan) begin
            pend_v[htid] <= 1'b1;
            pend_off[htid] <= hl_off;
            pend_lcp[htid] <= hl_lcp;
          end
        end
        if (accept) begin
          held <= 1'b1;
          htid <= blk_tid;
          smask <= blk_start;
          lcpm <= blk_lcp;
          hspan <= blk_span;
          hl_off <= lastpos;
          hl_lcp <= blk_lcp[lastpos];
          rem <= blk_span ? (blk_start & ~(WIN'(1) << lastpos)) : blk_start;
          head_v <= src_v;
          head_off <= src_off;
          head_len <= OW'(WIN - int'(src_off) + int'(blk_spill));
          head_lcp <= src_lcp;
          pend_v[blk_tid] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/predecode_window_chk.sv
module predecode_window_chk #(
  parameter int LANES = 6,
  parameter int SW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             iq_stall,
  input logic             blk_ready,
  input logic             fetch_slot,
  input logic [LANES-1:0] out_valid,
  input logic [LANES-1:0] out_span,
  input logic [SW-1:0]    stall_cnt
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  p_lanes_packed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_valid + 1'b1) & out_valid) == '0);
  p_slot_alt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> fetch_slot != $past(fetch_slot));
  p_span_lane0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_span != '0 |-> (out_span == LANES'(1) && out_valid[0]));
  p_lcp_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall_cnt != '0 |-> out_valid == '0);
  p_stall_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    iq_stall |-> out_valid == '0);
  p_flush_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (out_valid == '0 && !blk_ready));
  p_flush_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> out_valid == '0);
endmodule

bind predecode_window predecode_window_chk #(.LANES(LANES), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .iq_stall(iq_stall),
  .blk_ready(blk_ready), .fetch_slot(fetch_slot), .out_valid(out_valid),
  .out_span(out_span), .stall_cnt(stall_cnt)
);

// File: tb/predecode_window_tb.sv
`timescale 1ns/1ps
module predecode_window_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, blk_valid = 1'b0, blk_tid = 1'b0;
  logic [15:0] blk_start = '0, blk_lcp = '0;
  logic blk_span = 1'b0, iq_stall = 1'b0;
  logic [3:0] blk_spill = '0;
  logic blk_ready, fetch_slot, out_tid;
  logic [5:0] out_valid, out_span;
  logic [23:0] out_off, out_len;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  predecode_window dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .blk_valid(blk_valid), .blk_tid(blk_tid),
    .blk_start(blk_start), .blk_lcp(blk_lcp), .blk_span(blk_span), .blk_spill(blk_spill),
    .blk_ready(blk_ready), .fetch_slot(fetch_slot), .iq_stall(iq_stall),
    .out_valid(out_valid), .out_off(out_off), .out_len(out_len),
    .out_span(out_span), .out_tid(out_tid)
  );

  typedef struct packed {
    logic fl, bv, bt;
    logic [15:0] st, lc;
    logic sp;
    logic [3:0] sl;
    logic qs;
    logic er;
    logic [5:0] ev;
    logic et;
    logic [23:0] eo, el;
    logic [5:0] es;
  } row_t;

  localparam int NR = 24;
  localparam row_t TBL [NR] = '{
    '{0,1,0,16'h1555,16'h0,0,4'd0,0, 1,6'h00,0,24'h0,24'h0,6'h0},           // k0 7-start window, tid0
    '{0,1,1,16'h8889,16'h0,1,4'd0,0, 0,6'h3F,0,24'hA86420,24'h222222,6'h0}, // k1 R2 first six, R3 busy
    '{0,1,1,16'h8889,16'h0,1,4'd0,0, 1,6'h01,0,24'h00000C,24'h000004,6'h0}, // k2 R2 seventh; R5 tid1 refused in slot0
    '{0,1,1,16'h8889,16'h0,1,4'd0,0, 1,6'h00,0,24'h0,24'h0,6'h0},           // k3 R5 accepted in slot1
    '{0,1,1,16'h0108,16'h0,0,4'd3,0, 1,6'h0F,1,24'h00B730,24'h004443,6'h0}, // k4 R1 lengths, tail 15 parked
    '{0,1,1,16'h0108,16'h0,0,4'd3,0, 1,6'h00,0,24'h0,24'h0,6'h0},           // k5 continuation accepted
    '{0,0,0,16'h0,16'h0,0,4'd0,0,    1,6'h07,1,24'h00083F,24'h000854,6'h01},// k6 R4 tail len 16-15+3
    '{0,1,1,16'h0421,16'h0,0,4'd0,0, 1,6'h00,0,24'h0,24'h0,6'h0},           // k7
    '{0,0,0,16'h0,16'h0,0,4'd0,1,    0,6'h00,0,24'h0,24'h0,6'h0},           // k8 R7 backpressure
    '{0,0,0,16'h0,16'h0,0,4'd0,0,    1,6'h07,1,24'h000A50,24'h000655,6'h0}, // k9 R7 resumes intact
    '{0,1,0,16'h1111,16'h0010,0,4'd0,0, 1,6'h00,0,24'h0,24'h0,6'h0},        // k10 prefix flag on byte 4
    '{0,0,0,16'h0,16'h0,0,4'd0,0,    0,6'h03,0,24'h000040,24'h000044,6'h0}, // k11 R6 group ends at flagged
    '{0,0,0,16'h0,16'h0,0,4'd0,0,    0,6'h00,0,24'h0,24'h0,6'h0},           // k12 R6 stall
    '{0,0,0,16'h0,16'h0,0,4'd0,0,    0,6'h00,0,24'h0,24'h0,6'h0},           // k13 R6 stall
    '{0,0,0,16'h0,16'h0,0,4'd0,0,    1,6'h03,0,24'h0000C8,24'h000044,6'h0}, // k14 R6 remainder
    '{0,1,1,16'h0201,16'h0,1,4'd0,0, 1,6'h00,0,24'h0,24'h0,6'h0},           // k15 window with tail at 9
    '{0,0,0,16'h0,16'h0,0,4'd0,0,    1,6'h01,1,24'h000000,24'h000009,6'h0}, // k16
    '{1,0,0,16'h0,16'h0,0,4'd0,0,    0,6'h00,0,24'h0,24'h0,6'h0},           // k17 R8 flush
    '{0,0,0,16'h0,16'h0,0,4'd0,0,    1,6'h00,0,24'h0,24'h0,6'h0},           // k18
    '{0,1,1,16'h0044,16'h0,0,4'd2,0, 1,6'h00,0,24'h0,24'h0,6'h0},           // k19
    '{0,0,0,16'h0,16'h0,0,4'd0,0,    1,6'h03,1,24'h000062,24'h0000A4,6'h0}, // k20 R8 no tail after flush
    '{0,1,1,16'h1555,16'h0,0,4'd0,0, 1,6'h00,0,24'h0,24'h0,6'h0},           // k21
    '{1,0,0,16'h0,16'h0,0,4'd0,0,    0,6'h00,0,24'h0,24'h0,6'h0},           // k22 R8 flush held window
    '{0,0,0,16'h0,16'h0,0,4'd0,0,    1,6'h00,0,24'h0,24'h0,6'h0}            // k23 R8 nothing left
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] nib_mask(input logic [5:0] v);
    logic [23:0] m = '0;
    for (int l = 0; l < 6; l++) if (v[l]) m[l*4 +: 4] = 4'hF;
    return m;
  endfunction

  task automatic drive(input row_t r);
    flush = r.fl; blk_valid = r.bv; blk_tid = r.bt; blk_start = r.st; blk_lcp = r.lc;
    blk_span = r.sp; blk_spill = r.sl; iq_stall = r.qs;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    row_t idle;
    idle = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R9 ready in reset", 32'(blk_ready), 32'd1);
    chk("R9 valid in reset", 32'(out_valid), 32'd0);
    chk("R9 slot in reset", 32'(fetch_slot), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < NR; k++) begin
      drive(TBL[k]);
      #1;
      chk($sformatf("R5 slot k%0d", k), 32'(fetch_slot), 32'(k % 2));
      chk($sformatf("R3 ready k%0d", k), 32'(blk_ready), 32'(TBL[k].er));
      chk($sformatf("R2 valid k%0d", k), 32'(out_valid), 32'(TBL[k].ev));
      if (TBL[k].ev != '0) begin
        chk($sformatf("R1 offsets k%0d", k), 32'(out_off & nib_mask(TBL[k].ev)), 32'(TBL[k].eo));
        chk($sformatf("R1 lengths k%0d", k), 32'(out_len & nib_mask(TBL[k].ev)), 32'(TBL[k].el));
        chk($sformatf("R4 span k%0d", k), 32'(out_span), 32'(TBL[k].es));
        chk($sformatf("R5 tid k%0d", k), 32'(out_tid), 32'(TBL[k].et));
      end
      @(negedge clk);
    end
    drive(idle);
    // directed: reset mid-run, then a long backpressure window (R7)
    rst_n = 1'b0;
    #1;
    chk("R9 slot after reset", 32'(fetch_slot), 32'd0);
    chk("R9 valid after reset", 32'(out_valid), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(TBL[0]);
    iq_stall = 1'b1;
    @(negedge clk);
    drive(idle);
    iq_stall = 1'b1;
    for (int s = 0; s < 3; s++) begin
      #1;
      chk("R7 silent under stall", 32'(out_valid), 32'd0);
      chk("R7 ready held low", 32'(blk_ready), 32'd0);
      @(negedge clk);
    end
    iq_stall = 1'b0;
    #1;
    chk("R7 valid after stall", 32'(out_valid), 32'h3F);
    chk("R7 offsets after stall", 32'(out_off), 32'hA86420);
    @(negedge clk);
    #1;
    chk("R2 seventh after stall", 32'(out_valid), 32'h01);
    chk("R1 seventh offset", 32'(out_off[3:0]), 32'hC);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule